// File: doc/BRIEF.md
# Presettable Down Counter with Zero Decode

A small down counter intended for divide-by-N chains. It holds a count of `CNT_W` bits (four by default) that steps down by one on each rising edge of an external count clock, or, while that count clock rests high, on each falling edge of the hold input. A level on the clear input forces the count to zero. A level on the load input copies the preset word into the count. A decoded zero output reports the all-zeroes state while the feedback input is high. When the feedback input is low, the zero output instead mirrors the load input, which lets stages be chained.

The count clock and hold inputs are asynchronous to the system clock. Each passes through a synchronizer and is then edge-detected, so every piece of state lives in the system clock domain. Clear and load are sampled directly and act on the next system clock edge. A parameter selects the wrap value. In decade mode, stepping down from zero gives 9. In binary mode it gives the all-ones value. In both modes, presets above 9 count down in plain binary. Tying the load input to the zero output with feedback high makes a self-reloading divide-by-N stage.

Top module: `dn_divider`

## Requirements
- R1: With clear, load and hold low, a rising edge on `cnt_clk_i` lowers `count_o` by one. The new value is visible after the third rising system clock edge that follows the input change.
- R2: While `hold_i` is high, a rising edge on `cnt_clk_i` leaves `count_o` unchanged.
- R3: While `cnt_clk_i` is high, a falling edge on `hold_i` lowers `count_o` by one, with the same latency as R1. A later falling edge on `cnt_clk_i` has no effect.
- R4: `clr_i` high forces `count_o` to 0 at the next system clock edge. It overrides `load_i` and counting.
- R5: With `clr_i` low, `load_i` high copies `preset_i` into `count_o` at the next system clock edge and blocks counting. `preset_i[0]` is the least significant bit.
- R6: With `fb_i` high, `zero_o` is 1 exactly when `count_o` is 0. With `fb_i` low, `zero_o` equals `load_i`. Both relations are combinational.
- R7: Stepping down from 0 gives 9 when `MODE` is `MODE_DEC`, and 2^`CNT_W`-1 when `MODE` is `MODE_BIN`.
- R8: In decade mode, presets from 10 to 15 are accepted and step down in plain binary, for example 15 to 14.
- R9: With `load_i` tied to `zero_o`, `fb_i` high and preset N, `zero_o` pulses once per N count-clock rises. Each pulse is one system cycle wide, and the count then reloads N.
- R10: The count changes by at most one step per system cycle. A count-clock rise and a hold fall that arrive together give a single decrement.
- R11: Asynchronous `rst_ni` low sets `count_o` to 0 and clears the synchronizers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low system reset |
| clr_i | input | 1 | Functional clear, active high, highest priority |
| load_i | input | 1 | Preset enable, active high |
| preset_i | input | CNT_W | Preset word, bit 0 least significant |
| cnt_clk_i | input | 1 | Asynchronous count clock, counts on rising edge |
| hold_i | input | 1 | Inhibit level; its falling edge counts while cnt_clk_i is high |
| fb_i | input | 1 | Cascade feedback, selects the zero_o source |
| count_o | output | CNT_W | Current count |
| zero_o | output | 1 | Decoded zero or load echo |

## Verification
Clear and load act at the first system clock edge after they are driven. The bench drives them at a falling clock edge and samples at the next falling edge. A count-clock or hold change reaches `count_o` on the third rising edge. Each stimulus on those inputs is therefore followed by four falling edges before `count_o` is sampled, and the next stimulus waits another four. `zero_o` is combinational: it is sampled a fraction of a nanosecond after its driving input changes. In self-reload mode the bench samples it on every falling edge, so it can measure the width of each one-cycle pulse.

// File: rtl/dn_pkg.sv
package dn_pkg;
  typedef enum logic {MODE_BIN = 1'b0, MODE_DEC = 1'b1} wrap_mode_e;
  localparam int unsigned SYNC_DEPTH = 2;
endpackage

// File: rtl/dn_sync.sv
module dn_sync #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [DEPTH-1:0] stg_q;

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_stg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[i] <= 1'b0;
        else if (i == 0) stg_q[i] <= d_i;
        else stg_q[i] <= stg_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q_o = stg_q[DEPTH-1];
endmodule

// File: rtl/dn_edge.sv
module dn_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cclk_i,
  input  logic hold_i,
  output logic step_o
);
  logic cclk_q, hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cclk_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      cclk_q <= cclk_i;
      hold_q <= hold_i;
    end
  end

  logic rise_cnt, fall_hold;
  assign rise_cnt  = cclk_i & ~cclk_q & ~hold_i;
  assign fall_hold = hold_q & ~hold_i & cclk_i;
  // merged: both sources in one cycle still give one step
  assign step_o = rise_cnt | fall_hold;
endmodule

// File: rtl/dn_core.sv
module dn_core #(
  parameter int unsigned        CNT_W = 4,
  parameter dn_pkg::wrap_mode_e MODE  = dn_pkg::MODE_DEC
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] preset_i,
  input  logic             step_i,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] WRAP_VAL =
    (MODE == dn_pkg::MODE_DEC) ? CNT_W'(9) : {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)       cnt_d = '0;
    else if (load_i) cnt_d = preset_i;
    else if (step_i) cnt_d = (cnt_q == '0) ? WRAP_VAL : cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/dn_divider.sv
module dn_divider #(
  parameter int unsigned        CNT_W = 4,
  parameter dn_pkg::wrap_mode_e MODE  = dn_pkg::MODE_DEC
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] preset_i,
  input  logic             cnt_clk_i,
  input  logic             hold_i,
  input  logic             fb_i,
  output logic [CNT_W-1:0] count_o,
  output logic             zero_o
);
  localparam int unsigned N_ASYNC = 2;

  logic [N_ASYNC-1:0] raw_in, sync_out;
  logic               step;

  assign raw_in = {hold_i, cnt_clk_i};

  generate
    for (genvar i = 0; i < N_ASYNC; i++) begin : g_sync
      dn_sync #(.DEPTH(dn_pkg::SYNC_DEPTH)) u_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   (raw_in[i]),
        .q_o   (sync_out[i])
      );
    end
  endgenerate

  dn_edge u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cclk_i(sync_out[0]),
    .hold_i(sync_out[1]),
    .step_o(step)
  );

  dn_core #(.CNT_W(CNT_W), .MODE(MODE)) u_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr_i),
    .load_i  (load_i),
    .preset_i(preset_i),
    .step_i  (step),
    .count_o (count_o)
  );

  assign zero_o = fb_i ? (count_o == '0) : load_i;
endmodule

// File: rtl/dn_divider_chk.sv
module dn_divider_chk #(
  parameter int unsigned        CNT_W = 4,
  parameter dn_pkg::wrap_mode_e MODE  = dn_pkg::MODE_DEC
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clr_i,
  input logic             load_i,
  input logic [CNT_W-1:0] preset_i,
  input logic             fb_i,
  input logic [CNT_W-1:0] count_o,
  input logic             zero_o
);
  localparam logic [CNT_W-1:0] WRAP_VAL =
    (MODE == dn_pkg::MODE_DEC) ? CNT_W'(9) : {CNT_W{1'b1}};

  assert_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (count_o == '0));

  assert_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && load_i) |=> (count_o == $past(preset_i)));

  assert_zero_fb_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fb_i && count_o == '0) |-> zero_o);

  assert_zero_echo_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fb_i |-> (zero_o == load_i));

  assert_wrap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !load_i && count_o == '0) |=> (count_o == '0 || count_o == WRAP_VAL));

  assert_one_step_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !load_i && count_o != '0) |=>
      (count_o == $past(count_o) || count_o == $past(count_o) - 1'b1));
endmodule

bind dn_divider dn_divider_chk #(.CNT_W(CNT_W), .MODE(MODE)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .clr_i   (clr_i),
  .load_i  (load_i),
  .preset_i(preset_i),
  .fb_i    (fb_i),
  .count_o (count_o),
  .zero_o  (zero_o)
);

// File: tb/sim_dn_divider.sv
`timescale 1ns/1ps
module sim_dn_divider;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0, load_r = 1'b0, cclk = 1'b0, hold = 1'b0, fb = 1'b1;
  logic self_mode = 1'b0;
  logic [3:0] preset = 4'd0;
  logic [3:0] cnt0, cnt1;
  logic z0, z1, load0;
  int nchk = 0, nerr = 0;
  int exp0 = 0, exp1 = 0;
  int zero_hits = 0;
  logic zmon = 1'b0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  assign load0 = self_mode ? z0 : load_r;

  dn_divider #(.CNT_W(4), .MODE(dn_pkg::MODE_DEC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .load_i(load0), .preset_i(preset),
    .cnt_clk_i(cclk), .hold_i(hold), .fb_i(fb), .count_o(cnt0), .zero_o(z0));

  dn_divider #(.CNT_W(4), .MODE(dn_pkg::MODE_BIN)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .load_i(load_r), .preset_i(preset),
    .cnt_clk_i(cclk), .hold_i(hold), .fb_i(fb), .count_o(cnt1), .zero_o(z1));

  always @(negedge clk) if (zmon && z0) zero_hits++;

  function automatic int nxt(int v, int wrap);
    return (v == 0) ? wrap : v - 1;
  endfunction

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_load(int p);
    preset = 4'(p); load_r = 1'b1;
    settle(1);
    load_r = 1'b0;
    exp0 = p; exp1 = p;
  endtask

  task automatic cnt_pulse();
    cclk = 1'b1; settle(4);
    cclk = 1'b0; settle(4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  initial begin
    settle(2);
    // R11 reset state
    chk("R11 count0 in reset", int'(cnt0), 0);
    chk("R11 count1 in reset", int'(cnt1), 0);
    rst_n = 1'b1;
    settle(2);
    chk("R6 zero with fb high at 0", int'(z0), 1);

    // R5 exhaustive preset sweep
    for (int p = 0; p < 16; p++) begin
      do_load(p);
      chk("R5 load decade", int'(cnt0), p);
      chk("R5 load binary", int'(cnt1), p);
      chk("R6 zero decode", int'(z0), (p == 0) ? 1 : 0);
    end

    // R4 clear overrides load
    do_load(7);
    clr = 1'b1; load_r = 1'b1; preset = 4'd3;
    settle(1);
    chk("R4 clear over load", int'(cnt0), 0);
    chk("R4 clear over load bin", int'(cnt1), 0);
    clr = 1'b0; load_r = 1'b0; exp0 = 0; exp1 = 0;
    settle(1);

    // R1 R7 R8: count down from 15 through the wrap
    do_load(15);
    for (int k = 0; k < 20; k++) begin
      cnt_pulse();
      exp0 = nxt(exp0, 9); exp1 = nxt(exp1, 15);
      chk("R1 R8 R7 decade step", int'(cnt0), exp0);
      chk("R1 R7 binary step", int'(cnt1), exp1);
    end

    // R7 wrap from zero in both modes
    do_load(0);
    cnt_pulse();
    chk("R7 decade wrap", int'(cnt0), 9);
    chk("R7 binary wrap", int'(cnt1), 15);

    // R2 hold blocks counting
    do_load(6);
    hold = 1'b1; settle(4);
    cnt_pulse();
    chk("R2 hold blocks", int'(cnt0), 6);

    // R3 falling hold counts while cnt clock high
    cclk = 1'b1; settle(4);
    chk("R3 blocked rise", int'(cnt0), 6);
    hold = 1'b0; settle(4);
    chk("R3 hold fall counts", int'(cnt0), 5);
    cclk = 1'b0; settle(4);
    chk("R3 cnt clock fall ignored", int'(cnt0), 5);

    // R10 simultaneous rise and hold fall -> single step
    hold = 1'b1; settle(4);
    cclk = 1'b1; hold = 1'b0; settle(4);
    chk("R10 single step", int'(cnt0), 4);
    cclk = 1'b0; settle(4);

    // R5 load blocks counting
    preset = 4'd8; load_r = 1'b1;
    cclk = 1'b1; settle(4);
    cclk = 1'b0; settle(4);
    load_r = 1'b0; settle(1);
    chk("R5 load blocks count", int'(cnt0), 8);

    // R6 zero echoes load when fb low
    fb = 1'b0;
    preset = 4'd0; load_r = 1'b1; #1;
    chk("R6 echo load high", int'(z0), 1);
    settle(1);
    load_r = 1'b0; #1;
    chk("R6 echo load low at zero", int'(z0), 0);
    chk("R6 count is zero", int'(cnt0), 0);
    fb = 1'b1; #1;
    chk("R6 fb high decodes zero", int'(z0), 1);
    settle(1);

    // R9 self reload divide by 5
    preset = 4'd5; self_mode = 1'b1;
    clr = 1'b1; settle(2);
    clr = 1'b0; settle(2);
    chk("R9 initial reload", int'(cnt0), 5);
    zmon = 1'b1;
    for (int k = 0; k < 15; k++) cnt_pulse();
    zmon = 1'b0;
    chk("R9 pulse cycles in 3N rises", zero_hits, 3);
    chk("R9 count after 3N rises", int'(cnt0), 5);
    self_mode = 1'b0;

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule